// File: doc/BRIEF.md
# Disk Track Bitstream Replayer

This block stands in for the read side of a disk drive. A whole cylinder of already-encoded track images sits in on-chip memory. The block replays the selected track to a disk controller as a serial bit stream, one stored bit per bit period. The stored stream is opaque: gaps, address marks, headers, data and check bytes are all part of the image, and the block never looks inside it. The block also sources the bit clock and the index pulse, so the controller always samples on the emulated drive's own timing. That timing is ideal, with no jitter, no splice artifacts and no speed drift.

The head-select input forms the upper bits of the memory address. A head switch changes only those bits, so it takes effect within a bit period or two. One rotation counter is shared by all heads, so the angular position carries across a switch. A programmable track length in bits sets the wrap point. When the stream wraps back to bit 0, an index pulse of fixed width is raised. A read gate enables the serial output. If the gate rises too soon after a head change, the block raises a timing-violation pulse. A load port fills the cylinder between seeks, and it refuses writes aimed at the head being replayed.

Top module: `trackReplay`

## Requirements
- R1: Each stored word is sent most significant bit first, and words go out in increasing word address. The serial data equals the stored image bit for bit, zero-filled gap and sync patterns included.
- R2: `bitClk` has a period of CLK_DIV system clocks and is high for the first CLK_DIV/2 of them. While `readGate` is steady, `readData` changes only on the cycle in which `bitClk` rises.
- R3: After bit position `trackLenBits`-1, the next bit sent is position 0 of the same track.
- R4: `indexPulse` is high for exactly INDEX_LEN bit periods, starting with the period that carries bit 0, and is low for all other bit periods.
- R5: A change of `headSel` keeps the rotational bit offset and raises no index. The next bit period after the change carries the new head's bit at the next position.
- R6: While `readGate` is low, `readData` is 0.
- R7: `tooSoon` pulses for one cycle when `readGate` rises within SETTLE_CYC system clocks after a `headSel` change. A rise later than that produces no pulse.
- R8: A load with `loadEn` high writes `loadData` to word `loadWord` of track `loadHead`, unless `loadHead` equals the head being replayed. Such a load is dropped, the stored image is unchanged, and `loadReject` pulses one cycle later.
- R9: During reset every output is low except `bitClk`, which is high. The first bit period after reset carries bit position 0, with the index raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| trackLenBits | input | log2(WORDS_PER_TRACK*WORD_W)+1 | Track length in bits; sets the wrap point |
| headSel | input | log2(HEADS) | Head being replayed; upper address bits |
| readGate | input | 1 | Read request from the controller; enables the serial output |
| loadEn | input | 1 | Write strobe for the cylinder store |
| loadHead | input | log2(HEADS) | Track to write |
| loadWord | input | log2(WORDS_PER_TRACK) | Word address within the track |
| loadData | input | WORD_W | Word to store |
| bitClk | output | 1 | Bit clock sourced to the controller |
| readData | output | 1 | Serial encoded track data |
| indexPulse | output | 1 | Once-per-revolution index |
| tooSoon | output | 1 | Read gate raised inside the head settle window |
| loadReject | output | 1 | Load aimed at the live head was dropped |

## Verification
The bench replays tracks of several lengths, including one that is not a multiple of the word size. A design that wrapped at the end of a word, or at the full memory depth, would show misaligned data or a misplaced index there. A head switch made mid-rotation exposes a design that restarts at the index, or that keeps reading the old head for one stray bit. Read-gate rises just inside and well outside the settle window catch an off-by-window violation check. A load aimed at the live track, followed by a full revolution read back, reveals a design that lets such a write corrupt the track being replayed.

// File: rtl/trackPkg.sv
package trackPkg;
  // Strobes from the control side to the storage datapath
  typedef struct packed {
    logic shiftEn;  // advance the serial bit this cycle
    logic writeEn;  // commit the load-port word this cycle
  } dpStrobe_t;
endpackage

// File: rtl/trackDp.sv
module trackDp
  import trackPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int HEADS = 4,
  parameter int WORDS_PER_TRACK = 64,
  localparam int HEAD_W = (HEADS > 1) ? $clog2(HEADS) : 1,
  localparam int WORD_AW = (WORDS_PER_TRACK > 1) ? $clog2(WORDS_PER_TRACK) : 1,
  localparam int BIT_SW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [HEAD_W-1:0] rdHead,
  input  logic [WORD_AW-1:0] rdWord,
  input  logic [BIT_SW-1:0] rdBit,
  input  logic [HEAD_W-1:0] wrHead,
  input  logic [WORD_AW-1:0] wrWord,
  input  logic [WORD_W-1:0] wrData,
  output logic              bitOut
);
  localparam int ADDR_W = HEAD_W + WORD_AW;
  localparam int DEPTH = 1 << ADDR_W;

  // Cylinder store: head number is the upper address field
  logic [WORD_W-1:0] cylMem [DEPTH];
  logic [WORD_W-1:0] rdWordData;
  logic bitQ;

  always_ff @(posedge clk) begin
    if (strobe.writeEn) cylMem[{wrHead, wrWord}] <= wrData;
  end

  assign rdWordData = cylMem[{rdHead, rdWord}];

  // MSB first: bit offset 0 selects index WORD_W-1
  always_ff @(posedge clk) begin
    if (!rstN) bitQ <= 1'b0;
    else if (strobe.shiftEn) bitQ <= rdWordData[~rdBit];
  end

  assign bitOut = bitQ;

  // R8: the store is never written on the track being replayed
  assert_write_other_head_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeEn |-> (wrHead != rdHead));

  // R2: the serial bit only moves on a bit-clock tick
  assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(bitQ));
endmodule

// File: rtl/trackCtl.sv
module trackCtl
  import trackPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int HEADS = 4,
  parameter int WORDS_PER_TRACK = 64,
  parameter int CLK_DIV = 4,
  parameter int INDEX_LEN = 4,
  parameter int SETTLE_CYC = 750,
  localparam int HEAD_W = (HEADS > 1) ? $clog2(HEADS) : 1,
  localparam int WORD_AW = (WORDS_PER_TRACK > 1) ? $clog2(WORDS_PER_TRACK) : 1,
  localparam int BIT_SW = $clog2(WORD_W),
  localparam int POS_W = WORD_AW + BIT_SW,
  localparam int LEN_W = POS_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEN_W-1:0]   trackLenBits,
  input  logic [HEAD_W-1:0]  headSel,
  input  logic               readGate,
  input  logic               loadEn,
  input  logic [HEAD_W-1:0]  loadHead,
  output dpStrobe_t          strobe,
  output logic [HEAD_W-1:0]  rdHead,
  output logic [WORD_AW-1:0] rdWord,
  output logic [BIT_SW-1:0]  rdBit,
  output logic               bitClk,
  output logic               indexPulse,
  output logic               tooSoon,
  output logic               loadReject
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int IDX_W = $clog2(INDEX_LEN + 1);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);

  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic [POS_W-1:0] bitPos;
  logic [LEN_W-1:0] posInc;
  logic             wrapNow;
  logic [IDX_W-1:0] idxCnt;
  logic [HEAD_W-1:0] headQ;
  logic             headMoved;
  logic [SET_W-1:0] settleCnt;
  logic             gateD;
  logic             gateRise;

  // Bit clock divider
  assign tick = (divCnt == DIV_W'(CLK_DIV - 1));
  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end
  assign bitClk = (divCnt < DIV_W'(CLK_DIV / 2));

  // Rotation counter shared by all heads
  assign posInc = {1'b0, bitPos} + LEN_W'(1);
  assign wrapNow = (posInc >= trackLenBits);
  always_ff @(posedge clk) begin
    if (!rstN) bitPos <= '0;
    else if (tick) bitPos <= wrapNow ? '0 : posInc[POS_W-1:0];
  end

  // Index: armed on the tick that emits bit 0
  always_ff @(posedge clk) begin
    if (!rstN) idxCnt <= '0;
    else if (tick) begin
      if (bitPos == '0) idxCnt <= IDX_W'(INDEX_LEN);
      else if (idxCnt != '0) idxCnt <= idxCnt - 1'b1;
    end
  end
  assign indexPulse = (idxCnt != '0);

  // Head register and settle window
  assign headMoved = (headSel != headQ);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ <= '0;
      settleCnt <= '0;
    end else begin
      headQ <= headSel;
      if (headMoved) settleCnt <= SET_W'(SETTLE_CYC);
      else if (settleCnt != '0) settleCnt <= settleCnt - 1'b1;
    end
  end

  // Read-gate timing check and load guard
  assign gateRise = readGate & ~gateD;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateD <= 1'b0;
      tooSoon <= 1'b0;
      loadReject <= 1'b0;
    end else begin
      gateD <= readGate;
      tooSoon <= gateRise & (headMoved | (settleCnt != '0));
      loadReject <= loadEn & (loadHead == headQ);
    end
  end

  always_comb begin
    strobe.shiftEn = tick;
    strobe.writeEn = loadEn & (loadHead != headQ);
  end

  assign rdHead = headQ;
  assign rdWord = bitPos[POS_W-1:BIT_SW];
  assign rdBit = bitPos[BIT_SW-1:0];

  // R4: emitting bit 0 raises the index in the following cycle
  assert_index_on_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && bitPos == '0) |=> indexPulse);

  // R4: the index never starts anywhere but at bit 0
  assert_index_origin_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(indexPulse) |-> $past(tick && bitPos == '0));

  // R2: a new bit period starts with the bit clock high
  assert_clk_phase_R2: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> bitClk);

  // R7: a violation only follows a gate that was high
  assert_too_soon_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    tooSoon |-> $past(readGate));

  // R8: a reject only follows a load strobe
  assert_reject_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    loadReject |-> $past(loadEn));
endmodule

// File: rtl/trackReplay.sv
module trackReplay
  import trackPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int HEADS = 4,
  parameter int WORDS_PER_TRACK = 64,
  parameter int CLK_DIV = 4,
  parameter int INDEX_LEN = 4,
  parameter int SETTLE_CYC = 750,
  localparam int HEAD_W = (HEADS > 1) ? $clog2(HEADS) : 1,
  localparam int WORD_AW = (WORDS_PER_TRACK > 1) ? $clog2(WORDS_PER_TRACK) : 1,
  localparam int LEN_W = WORD_AW + $clog2(WORD_W) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEN_W-1:0]   trackLenBits,
  input  logic [HEAD_W-1:0]  headSel,
  input  logic               readGate,
  input  logic               loadEn,
  input  logic [HEAD_W-1:0]  loadHead,
  input  logic [WORD_AW-1:0] loadWord,
  input  logic [WORD_W-1:0]  loadData,
  output logic               bitClk,
  output logic               readData,
  output logic               indexPulse,
  output logic               tooSoon,
  output logic               loadReject
);
  localparam int BIT_SW = $clog2(WORD_W);

  dpStrobe_t          strobe;
  logic [HEAD_W-1:0]  rdHead;
  logic [WORD_AW-1:0] rdWord;
  logic [BIT_SW-1:0]  rdBit;
  logic               bitOut;

  trackCtl #(
    .WORD_W(WORD_W), .HEADS(HEADS), .WORDS_PER_TRACK(WORDS_PER_TRACK),
    .CLK_DIV(CLK_DIV), .INDEX_LEN(INDEX_LEN), .SETTLE_CYC(SETTLE_CYC)
  ) ctl (
    .clk(clk), .rstN(rstN), .trackLenBits(trackLenBits), .headSel(headSel),
    .readGate(readGate), .loadEn(loadEn), .loadHead(loadHead),
    .strobe(strobe), .rdHead(rdHead), .rdWord(rdWord), .rdBit(rdBit),
    .bitClk(bitClk), .indexPulse(indexPulse), .tooSoon(tooSoon),
    .loadReject(loadReject)
  );

  trackDp #(
    .WORD_W(WORD_W), .HEADS(HEADS), .WORDS_PER_TRACK(WORDS_PER_TRACK)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdHead(rdHead), .rdWord(rdWord),
    .rdBit(rdBit), .wrHead(loadHead), .wrWord(loadWord), .wrData(loadData),
    .bitOut(bitOut)
  );

  assign readData = bitOut & readGate;
endmodule

// File: tb/trackReplay_test.sv
`timescale 1ns/1ps
module trackReplay_test;
  localparam int WW = 16;
  localparam int NH = 4;
  localparam int NW = 16;
  localparam int DIV = 4;
  localparam int IDXL = 4;
  localparam int SETTLE = 750;

  localparam int NVEC = 5;
  localparam int VEC_HEAD [NVEC] = '{0, 1, 2, 3, 1};
  localparam int VEC_LEN  [NVEC] = '{256, 256, 200, 37, 100};

  logic clk = 0;
  logic rstN = 0;
  logic [8:0] trackLenBits = 9'd256;
  logic [1:0] headSel = 2'd3;
  logic readGate = 0;
  logic loadEn = 0;
  logic [1:0] loadHead = 0;
  logic [3:0] loadWord = 0;
  logic [15:0] loadData = 0;
  logic bitClk, readData, indexPulse, tooSoon, loadReject;
  logic bitClkD = 0;

  int total = 0;
  int bad = 0;
  logic [15:0] modelMem [NH][NW];

  trackReplay #(.WORD_W(WW), .HEADS(NH), .WORDS_PER_TRACK(NW), .CLK_DIV(DIV),
                .INDEX_LEN(IDXL), .SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rstN(rstN), .trackLenBits(trackLenBits), .headSel(headSel),
    .readGate(readGate), .loadEn(loadEn), .loadHead(loadHead), .loadWord(loadWord),
    .loadData(loadData), .bitClk(bitClk), .readData(readData),
    .indexPulse(indexPulse), .tooSoon(tooSoon), .loadReject(loadReject));

  always #10 clk = ~clk;
  always @(posedge clk) bitClkD <= bitClk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] patWord(int h, int w);
    int v;
    if (h == 0 && w < 2) return 16'h0000;   // leading gap
    if (h == 0 && w == 2) return 16'hA1A1;  // sync pattern
    v = (h + 1) * 40503 + w * 9973;
    return v[15:0] ^ 16'h5A3C;
  endfunction

  function automatic logic expBit(int h, int pos);
    logic [15:0] w;
    w = modelMem[h][pos / WW];
    return w[WW - 1 - (pos % WW)];
  endfunction

  task automatic nextBit(output logic b, output logic ix);
    do @(negedge clk); while (!(bitClk && !bitClkD));
    b = readData;
    ix = indexPulse;
  endtask

  task automatic syncIndex(output logic b);
    logic ix, prev;
    prev = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      nextBit(b, ix);
      if (ix && !prev) return;
      prev = ix;
    end
  endtask

  task automatic loadWrite(input int h, input int w, input logic [15:0] d,
                           output logic rej);
    @(negedge clk);
    loadEn = 1; loadHead = h[1:0]; loadWord = w[3:0]; loadData = d;
    @(negedge clk);
    rej = loadReject;
    loadEn = 0;
  endtask

  task automatic runVector(input int h, input int len, input string req);
    logic b, ix;
    int errs, pos;
    errs = 0;
    @(negedge clk);
    headSel = h[1:0];
    trackLenBits = len[8:0];
    syncIndex(b);
    if (b !== expBit(h, 0)) errs++;
    for (int i = 1; i <= len + 8; i++) begin
      nextBit(b, ix);
      pos = i % len;
      if (b !== expBit(h, pos) || ix !== (pos < IDXL)) errs++;
    end
    check(errs == 0, req, $sformatf("head %0d len %0d mismatches", h, len), errs, 0);
  endtask

  task automatic watchTooSoon(output int seen);
    seen = 0;
    repeat (3) begin
      @(negedge clk);
      if (tooSoon) seen++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    bad++; total++;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic b, ix, rej;
    int errs, cnt, hi, seen;
    logic prevD;

    for (int h = 0; h < NH; h++)
      for (int w = 0; w < NW; w++) modelMem[h][w] = patWord(h, w);

    // R9: reset state
    repeat (3) @(negedge clk);
    check(readData == 0 && indexPulse == 0 && tooSoon == 0 && loadReject == 0,
          "R9", "outputs low in reset", {readData, indexPulse, tooSoon, loadReject}, 0);
    check(bitClk == 1, "R9", "bitClk high in reset", bitClk, 1);
    @(negedge clk); rstN = 1;
    nextBit(b, ix);
    check(ix == 1, "R9", "first bit period carries index", ix, 1);

    // Preload: heads 0..2 while head 3 is live, then head 3 while head 0 is live
    errs = 0;
    for (int h = 0; h < NH - 1; h++)
      for (int w = 0; w < NW; w++) begin
        loadWrite(h, w, modelMem[h][w], rej);
        if (rej) errs++;
      end
    @(negedge clk); headSel = 2'd0;
    repeat (2) @(negedge clk);
    for (int w = 0; w < NW; w++) begin
      loadWrite(NH - 1, w, modelMem[NH - 1][w], rej);
      if (rej) errs++;
    end
    check(errs == 0, "R8", "loads to idle heads accepted", errs, 0);
    repeat (SETTLE + 50) @(negedge clk);
    readGate = 1;
    watchTooSoon(seen);
    check(seen == 0, "R7", "late gate rise not flagged", seen, 0);

    // R2: bit clock shape and data timing
    nextBit(b, ix);
    cnt = 0; hi = 0;
    do begin
      @(negedge clk); cnt++;
      if (bitClk) hi++;
    end while (!(bitClk && !bitClkD));
    check(cnt == DIV, "R2", "bit clock period", cnt, DIV);
    check(hi == DIV / 2, "R2", "bit clock high cycles", hi, DIV / 2);
    errs = 0;
    prevD = readData;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (readData !== prevD && !(bitClk && !bitClkD)) errs++;
      prevD = readData;
    end
    check(errs == 0, "R2", "data moves only at bit clock rise", errs, 0);

    // R1 R3 R4: replay vectors, including a length off the word grid
    for (int v = 0; v < NVEC; v++) runVector(VEC_HEAD[v], VEC_LEN[v], "R1 R3 R4");

    // R5: mid-rotation head switch keeps the offset
    @(negedge clk); headSel = 2'd0; trackLenBits = 9'd256;
    syncIndex(b);
    errs = 0;
    for (int i = 1; i < 50; i++) begin
      nextBit(b, ix);
      if (b !== expBit(0, i)) errs++;
    end
    headSel = 2'd2;
    for (int i = 50; i < 120; i++) begin
      nextBit(b, ix);
      if (b !== expBit(2, i) || ix !== 1'b0) errs++;
    end
    check(errs == 0, "R5", "offset kept across head switch", errs, 0);

    // R6: gate low silences the output
    @(negedge clk); readGate = 0;
    errs = 0;
    for (int i = 0; i < 40; i++) begin
      nextBit(b, ix);
      if (b !== 1'b0) errs++;
    end
    check(errs == 0, "R6", "readData low with gate low", errs, 0);

    // R7: settle window
    @(negedge clk); headSel = 2'd1;
    repeat (100) @(negedge clk);
    readGate = 1;
    watchTooSoon(seen);
    check(seen == 1, "R7", "early gate rise flagged", seen, 1);
    @(negedge clk); readGate = 0;
    repeat (5) @(negedge clk); headSel = 2'd3;
    repeat (SETTLE + 50) @(negedge clk);
    readGate = 1;
    watchTooSoon(seen);
    check(seen == 0, "R7", "gate rise after window not flagged", seen, 0);
    @(negedge clk); readGate = 0;
    repeat (5) @(negedge clk); headSel = 2'd0;
    repeat (SETTLE - 10) @(negedge clk);
    readGate = 1;
    watchTooSoon(seen);
    check(seen == 1, "R7", "gate rise near window end flagged", seen, 1);

    // R8: live-head load dropped, other-head load stored
    loadWrite(0, 3, 16'hFFFF, rej);
    check(rej == 1, "R8", "live-head load rejected", rej, 1);
    loadWrite(1, 5, 16'h1234, rej);
    check(rej == 0, "R8", "idle-head load accepted", rej, 0);
    modelMem[1][5] = 16'h1234;
    runVector(0, 256, "R8");
    runVector(1, 256, "R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule